// File: doc/BRIEF.md
# Page-Class-Aware Bank Mapper for a Distributed Shared Cache

This block sits beside each core's request path into a shared last-level cache whose banks form a square grid, one bank per core tile. For every access it decides which single bank must be looked up. The decision depends on the class of the page being touched, which the translation entry supplies together with the request. There are three classes:

- Private data always goes to the requesting core's own bank.
- Shared instructions go to one bank of a small 2x2 neighbourhood anchored at the requester. That bank is chosen through rotational bank tags, so every core sees all four tags in its own neighbourhood.
- Shared data is spread over every bank by block-interleaved address bits.

An access whose kind disagrees with the page class is refused. A fetch from a data page, a load or store to an instruction page, and any use of the reserved class code all raise a fault, and no bank is issued for them. The mapping is pure logic followed by one register stage, so every answer appears exactly one clock after its request. A new request may be presented on every cycle.

Top module: `nuca_bank_mapper`

## Requirements
- R1: While reset is asserted, and on the first sample after reset, map_valid, map_fault and map_bank are all zero.
- R2: A data access (req_fetch=0) to a private-data page (req_class=2'b00) yields map_valid=1 and map_bank equal to req_core, whatever the address.
- R3: An instruction fetch (req_fetch=1) to a shared-instruction page (req_class=2'b01) yields map_valid=1 and a bank inside the requester's wrapping 2x2 window. Bank b sits at row b/4 and column b%4, and core c sits on bank c. The window covers rows r and (r+1)%4 and columns k and (k+1)%4, where (r,k) is the requester's position.
- R4: For a granted shared-instruction fetch, the chosen bank's rotational tag equals req_addr[7:6]. The tag of the bank at (row,col) is (col + 2*(row%2)) % 4.
- R5: A data access to a shared-data page (req_class=2'b10) yields map_valid=1 and map_bank = req_addr[9:6], for any core.
- R6: An instruction fetch to a private-data or shared-data page yields map_fault=1, map_valid=0 and map_bank=0.
- R7: A data access to a shared-instruction page yields map_fault=1, map_valid=0 and map_bank=0.
- R8: The reserved class code 2'b11 yields map_fault=1, map_valid=0 and map_bank=0 for either access type.
- R9: A cycle with req_valid=0 yields map_valid=0, map_fault=0 and map_bank=0 one cycle later.
- R10: Each result appears exactly one clock after its request, including for back-to-back requests. map_valid and map_fault are never both high.
- R11: Address bits outside those named in R4 and R5 do not change the chosen bank. For private data, no address bit changes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| req_valid | input | 1 | Request present this cycle |
| req_core | input | 4 | Requesting core, equal to its local bank number |
| req_addr | input | 32 | Physical address of the access |
| req_class | input | 2 | Page class: 00 private data, 01 shared instruction, 10 shared data, 11 reserved |
| req_fetch | input | 1 | 1 for an instruction fetch, 0 for a data load or store |
| map_valid | output | 1 | Registered: map_bank names the bank to look up |
| map_bank | output | 4 | Registered bank number, zero unless map_valid |
| map_fault | output | 1 | Registered: access kind disagrees with page class |

## Verification
Every cycle, the bound checker confirms four things from the previous cycle's request. Valid and fault are exclusive. An idle cycle produces silence. Private and shared-data grants hit the local bank and the address-selected bank. Mismatched or reserved accesses fault without a bank. For instruction fetches the checker compares the granted bank's rotational tag with the address tag bits and measures its row and column distance from the requester. Neither check uses the window search that the design performs. Only the bench's exhaustive sweep over all cores, classes, access types and interleave fields shows the exact bank for each instruction case. The sweep also shows that results keep their order with no gap or slip across back-to-back requests, and that unrelated address bits leave the bank unchanged.

// File: rtl/nuca_map_pkg.sv
package nuca_map_pkg;

    // Page class codes as carried by the translation entry.
    typedef enum logic [1:0] {
        PG_PRIV_DATA    = 2'b00,
        PG_SHARED_INSTR = 2'b01,
        PG_SHARED_DATA  = 2'b10,
        PG_RESERVED     = 2'b11
    } page_class_e;

    // Rotational tags are two bits wide: one tag per member of a 2x2 window.
    localparam int unsigned ROT_W   = 2;
    localparam int unsigned WIN_CNT = 4;

    // Tag of the bank at a grid position: column modulo four, shifted by two
    // on odd rows, so any wrapping 2x2 window holds all four tags once.
    function automatic logic [ROT_W-1:0] rot_tag(input logic row_lsb,
                                                 input logic [ROT_W-1:0] col_lo);
        return col_lo + {row_lsb, 1'b0};
    endfunction

endpackage

// File: rtl/nuca_class_check.sv
module nuca_class_check
    import nuca_map_pkg::*;
(
    input  page_class_e cls_i,
    input  logic        fetch_i,
    output logic        fault_o
);

    logic is_instr_page;

    always_comb begin
        is_instr_page = (cls_i == PG_SHARED_INSTR);
        // A fetch must target an instruction page and a data access must not.
        fault_o = (cls_i == PG_RESERVED) | (fetch_i ^ is_instr_page);
    end

endmodule

// File: rtl/nuca_addr_fields.sv
module nuca_addr_fields
    import nuca_map_pkg::*;
#(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned LINE_OFF = 6,
    parameter int unsigned BANK_W   = 4
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [BANK_W-1:0] ilv_bank_o,
    output logic [ROT_W-1:0]  rot_sel_o
);

    // Lowest set-index bits above the line offset spread shared data over
    // all banks; the lowest two of them pick the rotational tag.
    always_comb begin
        ilv_bank_o = addr_i[LINE_OFF +: BANK_W];
        rot_sel_o  = addr_i[LINE_OFF +: ROT_W];
    end

endmodule

// File: rtl/nuca_rot_select.sv
module nuca_rot_select
    import nuca_map_pkg::*;
#(
    parameter int unsigned GRID_DIM = 4   // power of two, at least 4
) (
    input  logic [2*$clog2(GRID_DIM)-1:0] core_i,
    input  logic [ROT_W-1:0]              tag_i,
    output logic [2*$clog2(GRID_DIM)-1:0] bank_o
);

    localparam int unsigned RC_W   = $clog2(GRID_DIM);
    localparam int unsigned BANK_W = 2 * RC_W;

    logic [RC_W-1:0]   home_row;
    logic [RC_W-1:0]   home_col;
    logic [WIN_CNT-1:0] hit;
    logic [BANK_W-1:0] cand [WIN_CNT];

    assign home_row = core_i[BANK_W-1:RC_W];
    assign home_col = core_i[RC_W-1:0];

    // One candidate per window member; row and column wrap at the grid edge.
    for (genvar w = 0; w < WIN_CNT; w++) begin : g_win
        localparam logic [RC_W-1:0] DROW = RC_W'(w / 2);
        localparam logic [RC_W-1:0] DCOL = RC_W'(w % 2);
        logic [RC_W-1:0] c_row;
        logic [RC_W-1:0] c_col;
        always_comb begin
            c_row   = home_row + DROW;
            c_col   = home_col + DCOL;
            cand[w] = {c_row, c_col};
            hit[w]  = (rot_tag(c_row[0], c_col[ROT_W-1:0]) == tag_i);
        end
    end

    // Exactly one window member carries each tag, so an OR-merge selects it.
    always_comb begin
        bank_o = '0;
        for (int i = 0; i < WIN_CNT; i++) begin
            if (hit[i]) bank_o = bank_o | cand[i];
        end
    end

endmodule

// File: rtl/nuca_bank_mapper.sv
module nuca_bank_mapper
    import nuca_map_pkg::*;
#(
    parameter int unsigned GRID_DIM = 4,
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned LINE_OFF = 6
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              req_valid,
    input  logic [2*$clog2(GRID_DIM)-1:0]     req_core,
    input  logic [ADDR_W-1:0]                 req_addr,
    input  logic [1:0]                        req_class,
    input  logic                              req_fetch,
    output logic                              map_valid,
    output logic [2*$clog2(GRID_DIM)-1:0]     map_bank,
    output logic                              map_fault
);

    localparam int unsigned RC_W   = $clog2(GRID_DIM);
    localparam int unsigned BANK_W = 2 * RC_W;

    typedef struct packed {
        logic              vld;
        logic              flt;
        logic [BANK_W-1:0] bank;
    } map_rsp_t;

    map_rsp_t          rsp_d, rsp_q;
    page_class_e       cls;
    logic              kind_fault;
    logic [BANK_W-1:0] ilv_bank;
    logic [ROT_W-1:0]  rot_sel;
    logic [BANK_W-1:0] rot_bank;

    assign cls = page_class_e'(req_class);

    nuca_class_check u_class_check (
        .cls_i   (cls),
        .fetch_i (req_fetch),
        .fault_o (kind_fault)
    );

    nuca_addr_fields #(
        .ADDR_W   (ADDR_W),
        .LINE_OFF (LINE_OFF),
        .BANK_W   (BANK_W)
    ) u_addr_fields (
        .addr_i     (req_addr),
        .ilv_bank_o (ilv_bank),
        .rot_sel_o  (rot_sel)
    );

    nuca_rot_select #(
        .GRID_DIM (GRID_DIM)
    ) u_rot_select (
        .core_i (req_core),
        .tag_i  (rot_sel),
        .bank_o (rot_bank)
    );

    always_comb begin
        rsp_d = '0;
        if (req_valid) begin
            if (kind_fault) begin
                rsp_d.flt = 1'b1;
            end else begin
                rsp_d.vld = 1'b1;
                unique case (cls)
                    PG_PRIV_DATA:    rsp_d.bank = req_core;
                    PG_SHARED_INSTR: rsp_d.bank = rot_bank;
                    PG_SHARED_DATA:  rsp_d.bank = ilv_bank;
                    default:         rsp_d.bank = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign map_valid = rsp_q.vld;
    assign map_fault = rsp_q.flt;
    assign map_bank  = rsp_q.bank;

endmodule

// File: rtl/nuca_bank_mapper_chk.sv
module nuca_bank_mapper_chk
    import nuca_map_pkg::*;
#(
    parameter int unsigned GRID_DIM = 4,
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned LINE_OFF = 6
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          req_valid,
    input logic [2*$clog2(GRID_DIM)-1:0] req_core,
    input logic [ADDR_W-1:0]             req_addr,
    input logic [1:0]                    req_class,
    input logic                          req_fetch,
    input logic                          map_valid,
    input logic [2*$clog2(GRID_DIM)-1:0] map_bank,
    input logic                          map_fault
);

    localparam int unsigned RC_W   = $clog2(GRID_DIM);
    localparam int unsigned BANK_W = 2 * RC_W;

    logic [BANK_W-1:0] prev_core;
    logic [RC_W-1:0]   out_row, out_col, drow, dcol;
    logic [ROT_W-1:0]  out_tag;
    logic              is_priv, is_instr, is_sdata, is_bad;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_core <= '0;
        else        prev_core <= req_core;
    end

    always_comb begin
        out_row  = map_bank[BANK_W-1:RC_W];
        out_col  = map_bank[RC_W-1:0];
        drow     = out_row - prev_core[BANK_W-1:RC_W];
        dcol     = out_col - prev_core[RC_W-1:0];
        out_tag  = rot_tag(out_row[0], out_col[ROT_W-1:0]);
        is_priv  = req_valid && !req_fetch && req_class == 2'b00;
        is_instr = req_valid &&  req_fetch && req_class == 2'b01;
        is_sdata = req_valid && !req_fetch && req_class == 2'b10;
        is_bad   = req_valid && ((req_class == 2'b11) ||
                                 (req_fetch != (req_class == 2'b01)));
    end

    AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        !(map_valid && map_fault)); // R10

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!map_valid && !map_fault && map_bank == '0)); // R9

    AST_PRIV_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
        is_priv |=> (map_valid && map_bank == $past(req_core))); // R2

    AST_SDATA_ILV: assert property (@(posedge clk) disable iff (!rst_n)
        is_sdata |=> (map_valid && map_bank == $past(req_addr[LINE_OFF +: BANK_W]))); // R5

    AST_INSTR_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        is_instr |=> (map_valid && drow <= RC_W'(1) && dcol <= RC_W'(1))); // R3

    AST_INSTR_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        is_instr |=> (out_tag == $past(req_addr[LINE_OFF +: ROT_W]))); // R4

    AST_KIND_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        is_bad |=> (map_fault && !map_valid && map_bank == '0)); // R6

endmodule

bind nuca_bank_mapper nuca_bank_mapper_chk #(
    .GRID_DIM (GRID_DIM),
    .ADDR_W   (ADDR_W),
    .LINE_OFF (LINE_OFF)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_core  (req_core),
    .req_addr  (req_addr),
    .req_class (req_class),
    .req_fetch (req_fetch),
    .map_valid (map_valid),
    .map_bank  (map_bank),
    .map_fault (map_fault)
);

// File: tb/nuca_bank_mapper_bench.sv
`timescale 1ns/1ps
module nuca_bank_mapper_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [3:0]  req_core = '0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_class = '0;
    logic        req_fetch = 1'b0;
    logic        map_valid;
    logic [3:0]  map_bank;
    logic        map_fault;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    nuca_bank_mapper u_nuca_bank_mapper (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_core(req_core),
        .req_addr(req_addr), .req_class(req_class), .req_fetch(req_fetch),
        .map_valid(map_valid), .map_bank(map_bank), .map_fault(map_fault)
    );

    task automatic check_out(input string tag, input logic ev, input logic ef,
                             input int eb);
        checks++;
        if (map_valid !== ev || map_fault !== ef || int'(map_bank) != eb) begin
            errors++;
            $display("FAIL %s: got valid=%0b fault=%0b bank=%0d, expected valid=%0b fault=%0b bank=%0d",
                     tag, map_valid, map_fault, map_bank, ev, ef, eb);
        end
    endtask

    // Expected instruction bank by formula: step through the window by tag distance.
    function automatic int instr_bank(input int core, input int tag);
        int r, k, home, delta;
        r = core / 4; k = core % 4;
        home  = (k + 2 * (r % 2)) % 4;
        delta = (tag - home + 4) % 4;
        return ((r + delta / 2) % 4) * 4 + ((k + delta % 2) % 4);
    endfunction

    // Drive one request (caller is at a negedge) and check it one clock later.
    task automatic one_req(input int core, input int cls, input int fetch,
                           input logic [31:0] addr, input string tag);
        logic bad;
        int   eb;
        req_valid = 1'b1;
        req_core  = 4'(core);
        req_class = 2'(cls);
        req_fetch = 1'(fetch);
        req_addr  = addr;
        bad = (cls == 3) || ((fetch != 0) != (cls == 1));
        case (cls)
            0: eb = core;
            1: eb = instr_bank(core, int'(addr[7:6]));
            2: eb = int'(addr[9:6]);
            default: eb = 0;
        endcase
        @(negedge clk);
        if (bad) check_out(tag, 1'b0, 1'b1, 0);
        else     check_out(tag, 1'b1, 1'b0, eb);
    endtask

    task automatic idle_check();
        req_valid = 1'b0;
        req_addr  = 32'hFFFF_FFFF;
        req_class = 2'b01;
        @(negedge clk);
        check_out("R9 idle", 1'b0, 1'b0, 0);
    endtask

    initial begin
        // R1: a valid-looking request during reset must not appear.
        req_valid = 1'b1; req_class = 2'b10; req_addr = 32'h0000_03C0;
        repeat (3) @(negedge clk);
        check_out("R1 in reset", 1'b0, 1'b0, 0);
        req_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check_out("R1 after reset", 1'b0, 1'b0, 0);

        // Exhaustive sweep: core x class x type x interleave field, back to back (R10).
        for (int c = 0; c < 16; c++) begin
            for (int cl = 0; cl < 4; cl++) begin
                for (int f = 0; f < 2; f++) begin
                    for (int s = 0; s < 16; s++) begin
                        logic [31:0] a;
                        string t;
                        a = 32'(c * 32'h0123_4567) ^ 32'hDEAD_0000;
                        a[9:6] = 4'(s);
                        a[5:0] = 6'(c * 3 + s);
                        if (cl == 3)                t = "R8 reserved class";
                        else if (f == 1 && cl != 1) t = "R6 fetch to data page";
                        else if (f == 0 && cl == 1) t = "R7 data to instr page";
                        else if (cl == 0)           t = "R2 private local R10";
                        else if (cl == 1)           t = "R3 R4 rotational window R10";
                        else                        t = "R5 interleaved data R10";
                        one_req(c, cl, f, a, t);
                    end
                    if (((c + cl + f) % 5) == 0) idle_check();
                end
            end
        end

        // R11: unrelated address bits leave the bank unchanged.
        for (int c = 0; c < 16; c += 5) begin
            one_req(c, 0, 0, 32'h0000_0000, "R11 private addr zero");
            one_req(c, 0, 0, 32'hFFFF_FFFF, "R11 private addr ones");
            one_req(c, 1, 1, 32'hFFFF_FC80, "R11 instr high bits set");
            one_req(c, 1, 1, 32'h0000_0280, "R11 instr high bits clear");
            one_req(c, 2, 0, 32'hAAAA_A43F, "R11 data other bits");
        end
        idle_check();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule